// File: doc/BRIEF.md
# Error-Correcting Word Memory with Fault Injection

This block is a small single-port on-chip word memory. Every stored word carries a single-error-correct, double-error-detect (SECDED) code: an extended Hamming code with one extra overall parity bit. On a read, the block corrects a single flipped bit. It flags a word with two flipped bits and returns that word without correction. A control and status word sits on a separate register port. In that word, software turns checking on or off, arms one deliberate corruption of the write path, and collects sticky flags for corrected and uncorrectable reads. Each flag also drives an interrupt line.

The write path always computes the check bits. A pending injection flips one or two codeword bits on the first memory write that follows the arming. This lets software exercise its error handlers without a real fault.

The block has two resets. Cold reset clears the control word. Warm reset only restarts the read pipeline, so the flags and settings survive it.

Top module: `ecc_word_ram`

## Requirements
- R1: After cold reset the control word reads 0 and both interrupt outputs are low.
- R2: In the control word, bit 0 is check enable, bit 1 is arm-single, bit 2 is arm-double, bit 3 is the corrected-error flag and bit 4 is the uncorrectable-error flag. Bits 31..5 always read 0, and writes to them have no effect.
- R3: Asserting warm reset leaves every field of the control word, and the interrupt outputs, unchanged.
- R4: With checking enabled, a word written to an address reads back unchanged. Read data appears on `mem_rdata` in the cycle after the cycle in which `mem_re` is high, and a clean read sets no flag.
- R5: A register write that takes bit 1 from 0 to 1 arms one injection. The first memory write in a later cycle stores its codeword with bit 0 inverted. Reading that word returns the original data and sets bit 3. Later writes are clean, including while bit 1 is held at 1.
- R6: A register write that takes bit 2 from 0 to 1 arms one injection that inverts codeword bits 0 and 1 of the next memory write. Reading that word sets bit 4, leaves bit 3 alone and returns the uncorrected data.
- R7: Writing 1 to bit 3 or bit 4 clears that flag. Writing 0 leaves it as it is.
- R8: If a flag is set by a read and cleared by a register write in the same cycle, the flag ends up set.
- R9: With checking disabled, check bits are still stored, but reads are not checked and no flag is set. A word corrupted while checking was off raises the flag when it is read after checking is enabled again.
- R10: `irq_corr` follows bit 3 and `irq_uncorr` follows bit 4. Each stays high while its flag is 1. A flag is visible the cycle after the read data is presented.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| cold_rst_n | input | 1 | Active-low cold reset. Clears the control word and the read pipeline |
| warm_rst_n | input | 1 | Active-low warm reset. Clears only the read pipeline |
| mem_addr | input | ADDR_W | Word address for reads and writes |
| mem_wdata | input | DATA_W | Write data |
| mem_we | input | 1 | Memory write strobe |
| mem_re | input | 1 | Memory read strobe |
| mem_rdata | output | DATA_W | Read data, valid the cycle after `mem_re` |
| csr_we | input | 1 | Control word write strobe |
| csr_wdata | input | 32 | Control word write value |
| csr_rdata | output | 32 | Current control word |
| irq_corr | output | 1 | Level interrupt for a corrected single-bit error |
| irq_uncorr | output | 1 | Level interrupt for an uncorrectable error |

## Verification
The assertions assume a few things about the inputs:
- `mem_we` and `mem_re` never target the same address in the same cycle.
- Only the built-in injection corrupts a stored codeword.
- A flag clear counts only when it arrives through a `csr_we` cycle.

The directed stimulus respects all of this. It separates reads from writes, places every injected word at an address that no later write reuses, and changes the control word only through full-word register writes. Each of those writes spells out every defined field.

// File: rtl/ecc_word_ram.sv
module ecc_word_ram #(
  parameter int ADDR_W = 4,
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              cold_rst_n,
  input  logic              warm_rst_n,
  input  logic [ADDR_W-1:0] mem_addr,
  input  logic [DATA_W-1:0] mem_wdata,
  input  logic              mem_we,
  input  logic              mem_re,
  output logic [DATA_W-1:0] mem_rdata,
  input  logic              csr_we,
  input  logic [31:0]       csr_wdata,
  output logic [31:0]       csr_rdata,
  output logic              irq_corr,
  output logic              irq_uncorr
);

  function automatic int hbits(input int d);
    int h;
    h = 1;
    while ((1 << h) < d + h + 1) h++;
    return h;
  endfunction

  localparam int H     = hbits(DATA_W);
  localparam int CW    = DATA_W + H + 1;
  localparam int DEPTH = 1 << ADDR_W;

  function automatic logic [CW-1:0] encode(input logic [DATA_W-1:0] d);
    logic [CW-1:0] c;
    logic x;
    int k;
    c = '0;
    k = 0;
    for (int i = 1; i < CW; i++)
      if ((i & (i - 1)) != 0) begin
        c[i] = d[k];
        k++;
      end
    for (int p = 0; p < H; p++) begin
      x = 1'b0;
      for (int i = 1; i < CW; i++)
        if (((i >> p) & 1) != 0) x ^= c[i];
      c[1 << p] = x;
    end
    c[0] = ^c[CW-1:1];
    return c;
  endfunction

  function automatic logic [DATA_W-1:0] extract(input logic [CW-1:0] c);
    logic [DATA_W-1:0] d;
    int k;
    d = '0;
    k = 0;
    for (int i = 1; i < CW; i++)
      if ((i & (i - 1)) != 0) begin
        d[k] = c[i];
        k++;
      end
    return d;
  endfunction

  logic          ctl_en, ctl_is, ctl_id, st_corr, st_unc;
  logic          pend_s, pend_d;
  logic          rd_vld;
  logic [CW-1:0] rd_cw, fixed_cw, wr_cw, flip;
  logic [H-1:0]  syn;
  logic          par_odd, err_single, err_double;
  logic          set_corr, set_unc, arm_s, arm_d;
  logic          rst_any;

  logic [CW-1:0] mem [DEPTH];

  assign rst_any = cold_rst_n & warm_rst_n;

  // write path with one-shot corruption
  always_comb begin
    flip    = '0;
    flip[0] = pend_s | pend_d;
    flip[1] = pend_d;
  end
  assign wr_cw = encode(mem_wdata) ^ flip;

  always_ff @(posedge clk)
    if (mem_we) mem[mem_addr] <= wr_cw;

  always_ff @(posedge clk)
    if (mem_re) rd_cw <= mem[mem_addr];

  always_ff @(posedge clk or negedge rst_any)
    if (!rst_any) rd_vld <= 1'b0;
    else          rd_vld <= mem_re;

  // syndrome and correction
  always_comb begin
    syn = '0;
    for (int p = 0; p < H; p++)
      for (int i = 1; i < CW; i++)
        if (((i >> p) & 1) != 0) syn[p] = syn[p] ^ rd_cw[i];
    par_odd    = ^rd_cw;
    err_single = par_odd && (int'(syn) < CW);
    err_double = (!par_odd && syn != '0) || (par_odd && int'(syn) >= CW);
    fixed_cw   = rd_cw;
    if (ctl_en && err_single) fixed_cw[syn] = ~rd_cw[syn];
  end

  assign mem_rdata = extract(fixed_cw);

  // control and status word
  assign set_corr = rd_vld & ctl_en & err_single;
  assign set_unc  = rd_vld & ctl_en & err_double;
  assign arm_s    = csr_we & csr_wdata[1] & ~ctl_is;
  assign arm_d    = csr_we & csr_wdata[2] & ~ctl_id;

  always_ff @(posedge clk or negedge cold_rst_n)
    if (!cold_rst_n) begin
      ctl_en  <= 1'b0;
      ctl_is  <= 1'b0;
      ctl_id  <= 1'b0;
      st_corr <= 1'b0;
      st_unc  <= 1'b0;
      pend_s  <= 1'b0;
      pend_d  <= 1'b0;
    end else begin
      if (csr_we) begin
        ctl_en <= csr_wdata[0];
        ctl_is <= csr_wdata[1];
        ctl_id <= csr_wdata[2];
      end
      if (arm_s)       pend_s <= 1'b1;
      else if (mem_we) pend_s <= 1'b0;
      if (arm_d)       pend_d <= 1'b1;
      else if (mem_we) pend_d <= 1'b0;
      st_corr <= set_corr | (st_corr & ~(csr_we & csr_wdata[3]));
      st_unc  <= set_unc  | (st_unc  & ~(csr_we & csr_wdata[4]));
    end

  assign csr_rdata  = {27'd0, st_unc, st_corr, ctl_id, ctl_is, ctl_en};
  assign irq_corr   = st_corr;
  assign irq_uncorr = st_unc;

  assert_corr_sticky_R7: assert property (@(posedge clk) disable iff (!cold_rst_n)
    (st_corr && !(csr_we && csr_wdata[3])) |=> st_corr);

  assert_unc_sticky_R7: assert property (@(posedge clk) disable iff (!cold_rst_n)
    (st_unc && !(csr_we && csr_wdata[4])) |=> st_unc);

  assert_corr_set_wins_R8: assert property (@(posedge clk) disable iff (!cold_rst_n)
    (rd_vld && ctl_en && err_single) |=> irq_corr);

  assert_unc_set_R6: assert property (@(posedge clk) disable iff (!cold_rst_n)
    (rd_vld && ctl_en && err_double) |=> irq_uncorr);

  assert_pending_one_shot_R5: assert property (@(posedge clk) disable iff (!cold_rst_n)
    (pend_s && mem_we && !csr_we) |=> !pend_s);

  assert_no_flag_when_off_R9: assert property (@(posedge clk) disable iff (!cold_rst_n)
    (!ctl_en && !st_corr && !st_unc) |=> (!st_corr && !st_unc));

endmodule

// File: tb/ecc_word_ram_bench.sv
module ecc_word_ram_bench;
  localparam int AW = 4;
  localparam int DW = 32;

  logic clk = 1'b0;
  logic cold_rst_n = 1'b0, warm_rst_n = 1'b1;
  logic [AW-1:0] mem_addr = '0;
  logic [DW-1:0] mem_wdata = '0;
  logic mem_we = 1'b0, mem_re = 1'b0;
  logic [DW-1:0] mem_rdata;
  logic csr_we = 1'b0;
  logic [31:0] csr_wdata = '0;
  logic [31:0] csr_rdata;
  logic irq_corr, irq_uncorr;
  int n_vec = 0, n_bad = 0;

  always #5 clk = ~clk;

  ecc_word_ram #(.ADDR_W(AW), .DATA_W(DW)) u_ecc_word_ram (
    .clk(clk), .cold_rst_n(cold_rst_n), .warm_rst_n(warm_rst_n),
    .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_we(mem_we), .mem_re(mem_re),
    .mem_rdata(mem_rdata), .csr_we(csr_we), .csr_wdata(csr_wdata),
    .csr_rdata(csr_rdata), .irq_corr(irq_corr), .irq_uncorr(irq_uncorr));

  task automatic check(input string req, input logic [31:0] got, input logic [31:0] exp);
    n_vec++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s: got %h expected %h", req, got, exp);
    end
  endtask

  task automatic csr_wr(input logic [31:0] v);
    csr_we = 1'b1; csr_wdata = v;
    @(negedge clk);
    csr_we = 1'b0;
  endtask

  task automatic ram_wr(input logic [AW-1:0] a, input logic [DW-1:0] d);
    mem_we = 1'b1; mem_addr = a; mem_wdata = d;
    @(negedge clk);
    mem_we = 1'b0;
  endtask

  task automatic ram_rd(input logic [AW-1:0] a, output logic [DW-1:0] d);
    mem_re = 1'b1; mem_addr = a;
    @(negedge clk);
    mem_re = 1'b0;
    d = mem_rdata;
  endtask

  task automatic t_reset;
    check("R1 csr after reset", csr_rdata, 32'h0);
    check("R1 irqs after reset", {30'd0, irq_uncorr, irq_corr}, 32'h0);
  endtask

  task automatic t_reserved;
    csr_wr(32'hFFFF_FFE0);
    check("R2 reserved bits", csr_rdata, 32'h0);
  endtask

  task automatic t_plain;
    logic [DW-1:0] d;
    csr_wr(32'h1);
    ram_wr(0, 32'hDEAD_BEEF);
    ram_wr(1, 32'h0);
    ram_rd(0, d);
    check("R4 readback addr0", d, 32'hDEAD_BEEF);
    ram_rd(1, d);
    check("R4 readback addr1", d, 32'h0);
    @(negedge clk);
    check("R4 clean read no flag", csr_rdata, 32'h1);
  endtask

  task automatic t_inject_single;
    logic [DW-1:0] d;
    csr_wr(32'h3);
    ram_wr(2, 32'h1234_5678);
    ram_wr(3, 32'hA5A5_0F0F);
    ram_wr(4, 32'h8000_0001);
    ram_rd(3, d);
    check("R5 later write clean data", d, 32'hA5A5_0F0F);
    ram_rd(4, d);
    @(negedge clk);
    check("R5 held bit no further injection", csr_rdata, 32'h3);
    ram_rd(2, d);
    check("R5 corrected data", d, 32'h1234_5678);
    @(negedge clk);
    check("R5 corrected flag", csr_rdata, 32'h0B);
    check("R10 irq_corr high", {31'd0, irq_corr}, 32'h1);
    csr_wr(32'h3);
    ram_wr(6, 32'h0BAD_F00D);
    ram_rd(6, d);
    @(negedge clk);
    check("R5 rewrite of set bit does not arm", {d[3:0], 24'd0, csr_rdata[3:0]}, {4'hD, 24'd0, 4'hB});
  endtask

  task automatic t_inject_double;
    logic [DW-1:0] d;
    csr_wr(32'h5);
    ram_wr(9, 32'hCAFE_1234);
    ram_rd(9, d);
    check("R6 raw data returned", d, 32'hCAFE_1234);
    @(negedge clk);
    check("R6 uncorrectable flag", csr_rdata, 32'h1D);
    check("R10 irq_uncorr high", {31'd0, irq_uncorr}, 32'h1);
  endtask

  task automatic t_w1c;
    csr_wr(32'h1);
    check("R7 write 0 keeps flags", csr_rdata, 32'h19);
    csr_wr(32'h11);
    check("R7 clear uncorrectable", csr_rdata, 32'h09);
    check("R10 irq_uncorr low", {31'd0, irq_uncorr}, 32'h0);
    csr_wr(32'h09);
    check("R7 clear corrected", csr_rdata, 32'h01);
  endtask

  task automatic t_set_wins;
    logic [DW-1:0] d;
    ram_rd(2, d);
    csr_wr(32'h09);
    check("R8 set beats clear", csr_rdata, 32'h09);
    csr_wr(32'h09);
    check("R8 later clear works", csr_rdata, 32'h01);
    ram_rd(2, d);
    @(negedge clk);
    check("R10 flag one cycle after data", csr_rdata, 32'h09);
  endtask

  task automatic t_warm;
    logic [DW-1:0] d;
    warm_rst_n = 1'b0;
    repeat (3) @(negedge clk);
    warm_rst_n = 1'b1;
    @(negedge clk);
    check("R3 csr kept over warm reset", csr_rdata, 32'h09);
    check("R3 irq kept over warm reset", {30'd0, irq_uncorr, irq_corr}, 32'h1);
    ram_rd(0, d);
    check("R3 memory usable after warm reset", d, 32'hDEAD_BEEF);
  endtask

  task automatic t_disabled;
    logic [DW-1:0] d;
    csr_wr(32'h08);
    csr_wr(32'h02);
    ram_wr(8, 32'h5555_AAAA);
    ram_rd(8, d);
    check("R9 data with checking off", d, 32'h5555_AAAA);
    @(negedge clk);
    check("R9 no flag with checking off", csr_rdata, 32'h02);
    csr_wr(32'h01);
    ram_rd(8, d);
    @(negedge clk);
    check("R9 stored corruption seen once enabled", csr_rdata, 32'h09);
  endtask

  initial begin
    #200_000_0;
    n_bad++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    cold_rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_reserved();
    t_plain();
    t_inject_single();
    t_inject_double();
    t_w1c();
    t_set_wins();
    t_warm();
    t_disabled();
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end
endmodule